// File: doc/BRIEF.md
# Byte-Masked Command Register

This block is a 32-bit command register. Software does not write it with plain data. Each byte lane of a write carries one value bit in its top position and seven mask bits below it. Every bit position whose mask bit is 1 takes the lane's value bit. Every other bit position keeps what it held. Software can therefore set or clear any group of command bits in one write, with no read-modify-write and no race against other writers.

The low byte holds the command bits:
- a run control,
- an interrupt enable,
- a transmit suspend request,
- a receive suspend request.

The remaining non-value positions are spare control bits that the register stores and returns.

A small state machine tracks the run control through three states:
- `ST_LOAD`: a configuration load is pending, and the register is held at zero.
- `ST_STOP`: run is 0.
- `ST_RUN`: run is 1.

The transitions are as follows:
- Any state moves to `ST_LOAD` while the load-busy input is high.
- `ST_LOAD` leaves to `ST_STOP` or `ST_RUN` when busy falls, depending on the write in that cycle.
- `ST_STOP` moves to `ST_RUN` when a write sets run.
- `ST_RUN` moves to `ST_STOP` when a write clears run or a load error is reported.

Every exit from `ST_RUN` clears both suspend requests. It also raises a one-cycle strobe so that neighbouring logic can clear its demand bits, its legacy interrupt enable and its interrupt flags. A registered active-low interrupt output asserts only when the interrupt enable is set and at least one pending flag is present.

Top module: `cmdreg_ctl`

## Requirements
- R1: While `rst_n` is low, every register bit reads 0, `int_n` is 1 and `run_drop` is 0.
- R2: On an accepted write, for each byte lane L, each bit 8L+i (i = 0..6) whose written bit is 1 takes the value of written bit 8L+7. Bits written as 0 keep their old value. A write with all mask bits 0 changes nothing.
- R3: `rd_data` returns the stored bits. Bit positions 7, 15, 23 and 31 always read as 0.
- R4: Bit 0 is run, bit 1 is interrupt enable, bit 2 is transmit suspend and bit 3 is receive suspend. `ctl_run`, `ctl_tx_susp` and `ctl_rx_susp` equal bits 0, 2 and 3 of `rd_data`. All of them change at the clock edge that samples the write.
- R5: When run goes from 1 to 0, bits 2 and 3 become 0 at that same edge. The interrupt enable and the spare bits are left unchanged.
- R6: `run_drop` is 1 for exactly the one cycle after any edge at which run fell. The cause can be a write, a pending load or a load error.
- R7: `int_n` is registered. After an edge, it is 0 exactly when the interrupt enable and at least one `pend_flags` bit were both 1 before that edge.
- R8: With the interrupt enable at 0, `int_n` stays 1 whatever `pend_flags` holds.
- R9: While `cfg_load_busy` is 1, writes are ignored and the register clears to 0. A cycle with `cfg_load_err` at 1 also clears every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cfg_load_busy | input | 1 | Configuration load pending; holds the register clear |
| cfg_load_err | input | 1 | Configuration load failed; clears the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Per-lane value bit (top) and mask bits (lower seven) |
| rd_data | output | 32 | Stored register bits, value positions as 0 |
| pend_flags | input | 8 | Pending interrupt flags from neighbouring logic |
| ctl_run | output | 1 | Run control |
| ctl_tx_susp | output | 1 | Transmit suspend request |
| ctl_rx_susp | output | 1 | Receive suspend request |
| run_drop | output | 1 | One-cycle strobe after run falls |
| int_n | output | 1 | Registered interrupt output, active low |

## Verification
The register bits, `rd_data` and the three control outputs take their new value at the same edge that samples a write, load-busy or load-error cycle. `run_drop` rises at that same edge and stays for that one cycle only. `int_n` reflects the interrupt enable and flags as they stood just before an edge, so a write that sets the enable shows on `int_n` one edge later. The driver computes, for every cycle it drives, the expected values after the next rising edge. The monitor compares them 1 ns after that edge, so every result is sampled in the cycle it is due.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    // Positions of the command bits in the low byte lane.
    localparam int unsigned BIT_RUN = 0;
    localparam int unsigned BIT_IEN = 1;
    localparam int unsigned BIT_TXS = 2;
    localparam int unsigned BIT_RXS = 3;

    // Run-control tracking states.
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_STOP = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

endpackage

// File: rtl/cmdreg_lane.sv
// One byte lane of the value-and-mask merge (R2, R3).
module cmdreg_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] cur,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] wr_byte,
    output logic [LANE_W-1:0] nxt
);
    localparam int unsigned VB = LANE_W - 1;

    logic val;
    assign val = wr_byte[VB];

    always_comb begin
        for (int i = 0; i < VB; i++) begin
            nxt[i] = (wr_en && wr_byte[i]) ? val : cur[i];
        end
        // The value position is never stored.
        nxt[VB] = 1'b0;
    end
endmodule

// File: rtl/cmdreg_fsm.sv
// Run-control state machine (R4, R6, R9).
module cmdreg_fsm
    import cmdreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_busy,
    input  logic load_err,
    input  logic run_req,
    output logic run,
    output logic fall_now,
    output logic run_drop
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (load_busy)     state_d = ST_LOAD;
                else if (load_err) state_d = ST_STOP;
                else if (run_req)  state_d = ST_RUN;
                else               state_d = ST_STOP;
            end
            ST_STOP: begin
                if (load_busy)     state_d = ST_LOAD;
                else if (load_err) state_d = ST_STOP;
                else if (run_req)  state_d = ST_RUN;
                else               state_d = ST_STOP;
            end
            ST_RUN: begin
                if (load_busy)     state_d = ST_LOAD;
                else if (load_err) state_d = ST_STOP;
                else if (!run_req) state_d = ST_STOP;
                else               state_d = ST_RUN;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        run      = (state_q == ST_RUN);
        fall_now = (state_q == ST_RUN) && (state_d != ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_drop <= 1'b0;
        else        run_drop <= fall_now;
    end
endmodule

// File: rtl/cmdreg_irq.sv
// Registered, gated, active-low interrupt output (R7, R8).
module cmdreg_irq #(
    parameter int unsigned FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien,
    input  logic [FLAG_W-1:0] flags,
    output logic              int_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_n <= 1'b1;
        else        int_n <= ~(ien & (|flags));
    end
endmodule

// File: rtl/cmdreg_ctl.sv
module cmdreg_ctl
    import cmdreg_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned FLAG_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_load_busy,
    input  logic                      cfg_load_err,
    input  logic                      wr_en,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    output logic [LANES*LANE_W-1:0]   rd_data,
    input  logic [FLAG_W-1:0]         pend_flags,
    output logic                      ctl_run,
    output logic                      ctl_tx_susp,
    output logic                      ctl_rx_susp,
    output logic                      run_drop,
    output logic                      int_n
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] reg_d;
    logic              clr_all;
    logic              fall_now;
    logic              wr_ok;

    assign clr_all = cfg_load_busy | cfg_load_err;
    assign wr_ok   = wr_en & ~clr_all;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cmdreg_lane #(.LANE_W(LANE_W)) u_lane (
            .cur     (reg_q[g*LANE_W +: LANE_W]),
            .wr_en   (wr_ok),
            .wr_byte (wr_data[g*LANE_W +: LANE_W]),
            .nxt     (merged[g*LANE_W +: LANE_W])
        );
    end

    cmdreg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_busy (cfg_load_busy),
        .load_err  (cfg_load_err),
        .run_req   (merged[BIT_RUN]),
        .run       (ctl_run),
        .fall_now  (fall_now),
        .run_drop  (run_drop)
    );

    always_comb begin
        if (clr_all) begin
            reg_d = '0;
        end else begin
            reg_d = merged;
            if (fall_now) begin
                reg_d[BIT_TXS] = 1'b0;
                reg_d[BIT_RXS] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    cmdreg_irq #(.FLAG_W(FLAG_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ien   (reg_q[BIT_IEN]),
        .flags (pend_flags),
        .int_n (int_n)
    );

    assign rd_data     = reg_q;
    assign ctl_tx_susp = reg_q[BIT_TXS];
    assign ctl_rx_susp = reg_q[BIT_RXS];
endmodule

// File: rtl/cmdreg_ctl_chk.sv
module cmdreg_ctl_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned FLAG_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_load_busy,
    input logic                    cfg_load_err,
    input logic                    wr_en,
    input logic [LANES*LANE_W-1:0] wr_data,
    input logic [LANES*LANE_W-1:0] rd_data,
    input logic [FLAG_W-1:0]       pend_flags,
    input logic                    ctl_run,
    input logic                    run_drop,
    input logic                    int_n
);
    // R4: the state machine's run and the stored run bit agree.
    p_run_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_run == rd_data[0]);

    // R5: a falling run leaves both suspend requests at 0.
    p_susp_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |-> (rd_data[3:2] == 2'b00));

    // R6: the strobe follows every falling run.
    p_drop_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |-> run_drop);

    // R7: the interrupt only asserts from an enabled, flagged state.
    p_int_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> ($past(rd_data[1]) && $past(|pend_flags)));

    // R8: a disabled enable keeps the output inactive.
    p_int_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[1] |=> int_n);

    // R9: a pending load empties the register.
    p_load_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_busy |=> (rd_data == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R3: value positions never read as 1.
        p_value_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[g*LANE_W + LANE_W - 1] == 1'b0);

        // R2: a lane written with no mask bits keeps its contents.
        p_keep_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !cfg_load_busy && !cfg_load_err &&
             wr_data[g*LANE_W +: LANE_W-1] == '0)
            |=> $stable(rd_data[g*LANE_W +: LANE_W-1]));
    end
endmodule

bind cmdreg_ctl cmdreg_ctl_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .FLAG_W (FLAG_W)
) u_cmdreg_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load_busy (cfg_load_busy),
    .cfg_load_err  (cfg_load_err),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .pend_flags    (pend_flags),
    .ctl_run       (ctl_run),
    .run_drop      (run_drop),
    .int_n         (int_n)
);

// File: tb/test_cmdreg_ctl.sv
module test_cmdreg_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load_busy = 1'b0;
    logic        cfg_load_err = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  pend_flags = '0;
    logic        ctl_run, ctl_tx_susp, ctl_rx_susp, run_drop, int_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [31:0] rd;
        logic        irq_n;
        logic        drop;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] mdl = '0;

    always #5 clk = ~clk;

    cmdreg_ctl i_cmdreg_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load_busy (cfg_load_busy),
        .cfg_load_err  (cfg_load_err),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .pend_flags    (pend_flags),
        .ctl_run       (ctl_run),
        .ctl_tx_susp   (ctl_tx_susp),
        .ctl_rx_susp   (ctl_rx_susp),
        .run_drop      (run_drop),
        .int_n         (int_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] d);
        logic [31:0] r = cur;
        for (int l = 0; l < 4; l++) begin
            for (int i = 0; i < 7; i++) begin
                if (d[8*l+i]) r[8*l+i] = d[8*l+7];
            end
            r[8*l+7] = 1'b0;
        end
        return r;
    endfunction

    // Driver: one cycle of stimulus plus the expectation for the next edge.
    task automatic cyc(input logic wr, input logic [31:0] d, input logic busy,
                       input logic err, input logic [7:0] fl, input string tag);
        logic [31:0] nm;
        exp_t e;
        @(negedge clk);
        wr_en = wr; wr_data = d; cfg_load_busy = busy; cfg_load_err = err; pend_flags = fl;
        if (busy || err) nm = '0;
        else begin
            nm = wr ? merge(mdl, d) : mdl;
            if (mdl[0] && !nm[0]) nm[3:2] = 2'b00;
        end
        e.rd    = nm;
        e.irq_n = ~(mdl[1] & (|fl));
        e.drop  = mdl[0] & ~nm[0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mdl = nm;
    endtask

    task automatic idle(input int n, input logic [7:0] fl, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b0, 32'h0, 1'b0, 1'b0, fl, tag);
    endtask

    // Monitor: compares each expectation 1 ns after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " rd_data"}, rd_data, e.rd);
                check({t, " int_n"}, {31'b0, int_n}, {31'b0, e.irq_n});
                check({t, " run_drop"}, {31'b0, run_drop}, {31'b0, e.drop});
                check({t, " R4 ctl outputs"}, {29'b0, ctl_rx_susp, ctl_tx_susp, ctl_run},
                      {29'b0, e.rd[3], e.rd[2], e.rd[0]});
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 32'h0);
        check("R1 reset int_n", {31'b0, int_n}, 32'h1);
        check("R1 reset run_drop", {31'b0, run_drop}, 32'h0);
        rst_n = 1'b1;

        cyc(1'b1, 32'h0000_0083, 1'b0, 1'b0, 8'h00, "R4 set run and enable");
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 8'h04, "R7 flag raised");
        idle(1, 8'h04, "R7 interrupt asserted");
        cyc(1'b1, 32'hD500_0000, 1'b0, 1'b0, 8'h04, "R2 lane3 set masked");
        cyc(1'b1, 32'h0500_0000, 1'b0, 1'b0, 8'h00, "R2 lane3 clear masked");
        cyc(1'b1, 32'h0000_FF00, 1'b0, 1'b0, 8'h00, "R3 lane1 value bit reads zero");
        cyc(1'b1, 32'h0081_0000, 1'b0, 1'b0, 8'h00, "R2 lane2 single bit");
        cyc(1'b1, 32'h8080_8080, 1'b0, 1'b0, 8'h00, "R2 empty mask no change");
        cyc(1'b1, 32'h0000_2200, 1'b0, 1'b0, 8'h10, "R2 lane1 clear pair");
        cyc(1'b1, 32'h0000_0002, 1'b0, 1'b0, 8'h10, "R8 enable cleared");
        idle(3, 8'hFF, "R8 flags ignored");
        cyc(1'b1, 32'h0000_008C, 1'b0, 1'b0, 8'hFF, "R4 suspend requests set");
        cyc(1'b1, 32'h0000_0082, 1'b0, 1'b0, 8'hFF, "R5 enable set while running");
        cyc(1'b1, 32'h0000_0001, 1'b0, 1'b0, 8'hFF, "R5 run falls clears suspends");
        idle(2, 8'hFF, "R6 single strobe");
        cyc(1'b1, 32'h0000_0088, 1'b0, 1'b0, 8'h00, "R5 suspend set while stopped");
        cyc(1'b1, 32'h0000_0081, 1'b0, 1'b0, 8'h00, "R4 run set");
        cyc(1'b1, 32'h0000_00FF, 1'b1, 1'b0, 8'h01, "R9 load busy ignores write");
        cyc(1'b1, 32'h8181_8181, 1'b1, 1'b0, 8'h01, "R9 load busy holds clear");
        cyc(1'b1, 32'h0000_0083, 1'b0, 1'b0, 8'h01, "R9 write after load");
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 8'h01, "R7 interrupt after load");
        cyc(1'b0, 32'h0, 1'b0, 1'b1, 8'h01, "R9 load error clears");
        idle(2, 8'h01, "R6 strobe after load error");
        cyc(1'b1, 32'h00FF_0083, 1'b0, 1'b0, 8'h00, "R2 multi-lane write");
        idle(2, 8'h00, "R7 no flags");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset rd_data", rd_data, 32'h0);
        check("R1 async reset int_n", {31'b0, int_n}, 32'h1);
        mdl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b1, 32'h0000_0082, 1'b0, 1'b0, 8'h02, "R1 write after reset");
        idle(2, 8'h02, "R7 interrupt after reset");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule